// File: doc/BRIEF.md
# Self-Clearing Clock-Gated Output Register

This block is a register of parameterized width that holds a copy of its data input while a control line is high, and that drives its output to zero once the control line goes low. The register runs from a locally gated clock so that it draws no clock power while idle. The gate is a glitch-free latch-and-AND cell written in RTL.

The value presented to the flop is the data input masked by the control line. The gate enable is the control line ORed with "output is nonzero". When control falls while the output still holds data, the gate stays open for one more clock edge. That edge loads zero, the enable then drops, and the clock stops. No logic sits between the flop and the output pin, so the output has a clean clock-to-output path. The gated clock is also driven out on a port so that a consumer, or a test, can see it.

Top module: `sc_gated_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros and `gclk_o` stays low. After reset is released with `ctrl` low, `gclk_o` produces no rising edges.
- R2: After every rising `clk` edge at which `ctrl` was high, `q` equals the `din` value sampled at that edge.
- R3: `gclk_o` rises on every `clk` rising edge at which `ctrl` is high.
- R4: If `ctrl` is low at a `clk` edge while `q` is nonzero, exactly one gated edge occurs and loads zero into `q`. No further gated edges occur while `ctrl` stays low.
- R5: If `ctrl` falls while `q` is already zero, no gated edge occurs.
- R6: While `ctrl` is low, changes on `din` have no effect: `q` stays zero and `gclk_o` stays idle.
- R7: If `ctrl` rises again right after the clearing edge, the next `clk` edge is gated through and `q` captures `din` there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 1 | Capture control; low forces the output to zero |
| din | input | W | Data input |
| q | output | W | Registered output, driven directly by the flop |
| gclk_o | output | 1 | Gated clock that drives the register |

## Verification
The bench feeds several different data words through while `ctrl` is high. Each capture is checked against the word driven one edge earlier, which shows that every edge really loads new data.

It then drops `ctrl` twice. The first time `q` holds a nonzero word, and the bench expects exactly one gated edge. The second time `q` already holds zero, and the bench expects no gated edge at all. Together these show that the gate enable depends on the register's own content.

With `ctrl` low, the bench toggles `din`, which must leave both `q` and the gated-edge count unchanged. Finally it raises `ctrl` again just after a clearing edge, to confirm that capture resumes with no lost pulse.

// File: rtl/sc_gated_reg_pkg.sv
package sc_gated_reg_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  function automatic logic any_set(input logic [63:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/sc_clk_gate.sv
module sc_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic en_q,
  output logic gclk
);
  logic en_lat;

  // transparent while clk is low; frozen across the high phase
  always_latch begin
    if (!rst_n)    en_lat = 1'b0;
    else if (!clk) en_lat = en_i;
  end

  assign en_q = en_lat;
  assign gclk = clk & en_lat;
endmodule

// File: rtl/sc_data_mask.sv
module sc_data_mask #(
  parameter int unsigned W = 8
) (
  input  logic         ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] d
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign d[i] = din[i] & ctrl;
  end
endmodule

// File: rtl/sc_gated_reg.sv
module sc_gated_reg #(
  parameter int unsigned W = sc_gated_reg_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         gclk_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] d_masked;
  logic [W-1:0] q_r;
  logic         gate_en;
  logic         en_q;
  logic         gclk;

  sc_data_mask #(.W(W)) u_mask (
    .ctrl (ctrl),
    .din  (din),
    .d    (d_masked)
  );

  always_comb gate_en = ctrl | (q_r != ZERO);

  sc_clk_gate u_icg (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (gate_en),
    .en_q  (en_q),
    .gclk  (gclk)
  );

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) q_r <= ZERO;
    else        q_r <= d_masked;
  end

  assign q      = q_r;
  assign gclk_o = gclk;

  // R2: capture when control was high at the previous edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl)) |-> (q == $past(din)));

  // R4 / R6: output is zero after any edge with control low
  a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl)) |-> (q == ZERO));

  // R3: gate open whenever control is high
  a_r3_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl |-> en_q);

  // R5: no gated edge with control low and nothing to clear
  a_r5_idle_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl && q == ZERO) |-> !en_q);

  // R4: extra edge granted while data remains
  a_r4_extra_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl && q != ZERO) |-> en_q);
endmodule

// File: tb/sc_gated_reg_tb.sv
`timescale 1ns/1ps
module sc_gated_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ctrl;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         gclk_o;

  int checks   = 0;
  int failures = 0;
  int edges    = 0;

  always #10 clk = ~clk;

  sc_gated_reg #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .din(din), .q(q), .gclk_o(gclk_o)
  );

  always @(posedge gclk_o) edges++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive inputs at a falling edge, return after the following falling edge
  task automatic step(input logic c, input logic [W-1:0] d);
    ctrl = c;
    din  = d;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int e0;
    rst_n = 1'b0; ctrl = 1'b0; din = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 q in reset", q, 0);
    chk("R1 gclk in reset", edges, 0);
    rst_n = 1'b1;
    e0 = edges;
    repeat (3) step(1'b0, 8'hA5);
    chk("R1 no edges after reset", edges - e0, 0);
    chk("R1 q after reset", q, 0);
  endtask

  task automatic t_capture();
    logic [W-1:0] pats [4] = '{8'h5A, 8'hFF, 8'h01, 8'h80};
    int e0 = edges;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, pats[i]);
      chk("R2 capture", q, pats[i]);
    end
    chk("R3 one edge per clk", edges - e0, 4);
  endtask

  task automatic t_drop_nonzero();
    int e0;
    step(1'b1, 8'hC3);
    chk("R2 load before drop", q, 8'hC3);
    e0 = edges;
    step(1'b0, 8'hFF);
    chk("R4 cleared", q, 0);
    chk("R4 one extra edge", edges - e0, 1);
    repeat (4) step(1'b0, 8'hFF);
    chk("R4 clock stopped", edges - e0, 1);
  endtask

  task automatic t_drop_zero();
    int e0;
    step(1'b1, 8'h00);
    chk("R2 zero load", q, 0);
    e0 = edges;
    repeat (3) step(1'b0, 8'h00);
    chk("R5 no edge", edges - e0, 0);
  endtask

  task automatic t_ignore();
    int e0 = edges;
    step(1'b0, 8'h11);
    step(1'b0, 8'hEE);
    step(1'b0, 8'h7F);
    chk("R6 q held low", q, 0);
    chk("R6 no edge", edges - e0, 0);
  endtask

  task automatic t_rerise();
    int e0;
    step(1'b1, 8'h3C);
    e0 = edges;
    step(1'b0, 8'hAA);
    chk("R7 clearing edge", q, 0);
    step(1'b1, 8'h96);
    chk("R7 capture resumes", q, 8'h96);
    chk("R7 no lost pulse", edges - e0, 2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_capture();
    t_drop_nonzero();
    t_drop_zero();
    t_ignore();
    t_rerise();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule